// File: doc/BRIEF.md
# Fall-Through Slot FIFO

This block is a first-in first-out buffer placed between a producer and a consumer that run at different data rates on one shared clock. The producer offers a word and pulses a load strobe. The consumer reads the word at the far end and pulses a remove strobe. Storage is a chain of slots. Each slot holds one data word and one occupancy mark.

A word that enters the chain does not wait for a read. On each clock it moves one slot closer to the output end whenever the slot in front of it is empty, so words pack up against the output. Two flags form the handshake. The out-ready flag says that a valid word is on the output, and the in-ready flag says that the entry slot can take a word. Any strobe given while its flag is low is ignored. The default chain is 64 slots of 4-bit words.

Top module: `ft_fifo`

## Requirements
- R1: While reset is held and just after it, out_ready is 0 and in_ready is 1, so the buffer reads as empty.
- R2: Words leave in the order in which they were accepted. A word is accepted when shift_in is 1 and in_ready is 1 at a rising edge. It is removed when shift_out is 1 and out_ready is 1 at a rising edge. Every removed word equals the oldest accepted word still held.
- R3: A word accepted into an empty buffer at edge k makes out_ready 1 after edge k+DEPTH-1 and not earlier. With the default DEPTH this is 63 cycles.
- R4: shift_in while in_ready is 0 is ignored. No word is stored, and no held word is overwritten or lost. A slot is never loaded while it is occupied.
- R5: shift_out while out_ready is 0 is ignored. No word is removed from any slot.
- R6: When shift_in and shift_out are both legal at the same edge, both take effect.
- R7: While out_ready is 1 and shift_out is 0, out_ready stays 1 and data_out holds its value. Every occupied slot keeps its word until that word moves on.
- R8: A word moves only into a slot that was empty before the edge. After a removal, out_ready is 0 for the next cycle, and it returns one cycle later if a word was waiting directly behind the output slot.
- R9: The buffer holds exactly DEPTH words. With loads offered on every cycle and no removals, exactly DEPTH words are accepted. in_ready then stays 0 and out_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset that clears every occupancy mark |
| shift_in | input | 1 | Load strobe for data_in |
| data_in | input | WIDTH | Word offered at the entry slot |
| in_ready | output | 1 | 1 when the entry slot is empty |
| shift_out | input | 1 | Remove strobe for the word on data_out |
| data_out | output | WIDTH | Word held in the output slot |
| out_ready | output | 1 | 1 when the output slot holds a valid word |

## Verification
A single word with remove strobes given too early measures the fall-through time exactly. It also separates a correct design from one that removes a word before it has arrived. A fill phase with loads on every cycle finds the capacity and shows that refused loads leave no trace. A pop from a full chain then shows the one-cycle bubble at the output. Loads and removes held high together stream words through the chain and show that both strobes take effect at the same edge. A scoreboard compares every removed word, so any reordering, loss or duplication is reported.

// File: rtl/ft_fifo_pkg.sv
package ft_fifo_pkg;
  localparam int unsigned DEF_DEPTH = 64;
  localparam int unsigned DEF_WIDTH = 4;

  // Occupancy of one slot after an edge.
  function automatic logic next_mark(input logic take, input logic held, input logic give);
    return take | (held & ~give);
  endfunction

  // Edges a lone word needs to go from the entry slot to the output slot.
  function automatic int unsigned settle_cycles(input int unsigned depth);
    return depth - 1;
  endfunction
endpackage

// File: rtl/ft_slot.sv
module ft_slot #(
  parameter int unsigned WIDTH = ft_fifo_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             give,
  input  logic [WIDTH-1:0] din,
  output logic             mark,
  output logic [WIDTH-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark <= 1'b0;
      word <= '0;
    end else begin
      mark <= ft_fifo_pkg::next_mark(take, mark, give);
      if (take) word <= din;
    end
  end

  // R4: the controller never loads an occupied slot
  a_r4_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !mark);

  // R7: a held word stays put until it is given away
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && !give) |=> (mark && $stable(word)));
endmodule

// File: rtl/ft_ctrl.sv
module ft_ctrl #(
  parameter int unsigned DEPTH = ft_fifo_pkg::DEF_DEPTH
) (
  input  logic [DEPTH-1:0] mark,
  input  logic             shift_in,
  input  logic             shift_out,
  output logic [DEPTH-1:0] take,
  output logic [DEPTH-1:0] give,
  output logic             push,
  output logic             pop
);
  localparam int unsigned LAST = DEPTH - 1;

  // A slot advances when it is full and the slot in front of it is empty.
  function automatic logic [DEPTH-2:0] advance_mask(input logic [DEPTH-1:0] m);
    logic [DEPTH-1:0] ahead_free;
    ahead_free = ~(m >> 1);
    return m[DEPTH-2:0] & ahead_free[DEPTH-2:0];
  endfunction

  logic [DEPTH-2:0] adv;

  always_comb begin
    adv  = advance_mask(mark);
    push = shift_in & ~mark[0];
    pop  = shift_out & mark[LAST];
    take = {adv, push};
    give = {pop, adv};
  end
endmodule

// File: rtl/ft_fifo.sv
module ft_fifo #(
  parameter int unsigned DEPTH = ft_fifo_pkg::DEF_DEPTH,
  parameter int unsigned WIDTH = ft_fifo_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] data_in,
  output logic             in_ready,
  input  logic             shift_out,
  output logic [WIDTH-1:0] data_out,
  output logic             out_ready
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] mark;
  logic [DEPTH-1:0] take;
  logic [DEPTH-1:0] give;
  logic [WIDTH-1:0] word [DEPTH];
  logic             push;
  logic             pop;

  ft_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .mark(mark), .shift_in(shift_in), .shift_out(shift_out),
    .take(take), .give(give), .push(push), .pop(pop)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [WIDTH-1:0] feed;
    if (i == 0) begin : g_head
      assign feed = data_in;
    end else begin : g_body
      assign feed = word[i-1];
    end
    ft_slot #(.WIDTH(WIDTH)) u_slot (
      .clk(clk), .rst_n(rst_n), .take(take[i]), .give(give[i]),
      .din(feed), .mark(mark[i]), .word(word[i])
    );
  end

  assign in_ready  = ~mark[0];
  assign out_ready = mark[LAST];
  assign data_out  = word[LAST];

  // Lets $past-based checks start one edge after reset.
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2 / R6: the number of held words changes only by accepted loads and removals
  a_r2_conserve: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    int'($countones(mark)) == int'($past($countones(mark))) + int'($past(push)) - int'($past(pop)));

  // R8: a removal leaves a bubble at the output
  a_r8_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && shift_out) |=> !out_ready);

  // R5: a removal strobe on an empty output slot with nothing behind it changes nothing
  a_r5_idle_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && shift_out && !mark[LAST-1]) |=> !out_ready);
endmodule

// File: tb/tb_ft_fifo.sv
module tb_ft_fifo;
  localparam int D = 64;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift_in = 1'b0;
  logic [W-1:0] data_in = '0;
  logic         shift_out = 1'b0;
  logic         in_ready;
  logic         out_ready;
  logic [W-1:0] data_out;

  always #5 clk = ~clk;

  ft_fifo #(.DEPTH(D), .WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .data_in(data_in),
    .in_ready(in_ready), .shift_out(shift_out), .data_out(data_out),
    .out_ready(out_ready)
  );

  logic [W-1:0] exp_q[$];
  int checks = 0, errors = 0;
  int pushes = 0, pops = 0, refused = 0, both = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: sample at the falling edge, record, drive, wait for the next falling edge.
  task automatic step(input logic si, input logic [W-1:0] d, input logic so);
    logic acc_i, acc_o;
    logic [W-1:0] e;
    acc_i = si && in_ready;
    acc_o = so && out_ready;
    if (acc_o) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected word", int'(data_out), -1);
      else begin
        e = exp_q.pop_front();
        check(data_out == e, "R2 order", int'(data_out), int'(e));
      end
      pops++;
    end
    if (acc_i) begin exp_q.push_back(d); pushes++; end
    if (acc_i && acc_o) both++;
    if (si && !in_ready) refused++;
    shift_in = si; data_in = d; shift_out = so;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int n = 0; n < 1000 && exp_q.size() > 0; n++) step(1'b0, '0, 1'b1);
    check(exp_q.size() == 0, "R2 drained", exp_q.size(), 0);
    for (int n = 0; n < D + 16; n++) step(1'b0, '0, 1'b0);
    check(out_ready == 1'b0, "R4 no extra word", int'(out_ready), 0);
    check(in_ready == 1'b1, "R4 entry free", int'(in_ready), 1);
  endtask

  initial begin
    int acc0;
    repeat (3) @(negedge clk);
    check(out_ready == 1'b0, "R1 out_ready in reset", int'(out_ready), 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_ready == 1'b0, "R1 out_ready after reset", int'(out_ready), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R3 latency, R5 early remove strobes
    step(1'b1, 4'hA, 1'b1);
    for (int k = 1; k < D - 1; k++) step(1'b0, '0, 1'b1);
    check(out_ready == 1'b0, "R3 not yet at output", int'(out_ready), 0);
    step(1'b0, '0, 1'b0);
    check(out_ready == 1'b1, "R3/R5 word arrived", int'(out_ready), 1);
    check(data_out == 4'hA, "R5 word intact", int'(data_out), 10);
    for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0);
    check(out_ready == 1'b1 && data_out == 4'hA, "R7 held", int'(data_out), 10);
    step(1'b0, '0, 1'b1);
    check(out_ready == 1'b0, "R8 empty after pop", int'(out_ready), 0);

    // R9 capacity and R4 refused loads
    acc0 = pushes;
    for (int k = 0; k < 400; k++) step(1'b1, W'(k * 7 + 3), 1'b0);
    check(pushes - acc0 == D, "R9 capacity", pushes - acc0, D);
    check(in_ready == 1'b0, "R9 in_ready full", int'(in_ready), 0);
    check(out_ready == 1'b1, "R9 out_ready full", int'(out_ready), 1);
    check(refused > 0, "R4 refused loads seen", refused, 1);
    step(1'b0, '0, 1'b1);
    check(out_ready == 1'b0, "R8 bubble", int'(out_ready), 0);
    step(1'b0, '0, 1'b0);
    check(out_ready == 1'b1, "R8 refill", int'(out_ready), 1);
    drain();

    // R6 streaming with both strobes high
    for (int k = 0; k < 70; k++) step(1'b1, W'(k * 5 + 1), 1'b0);
    for (int k = 0; k < 300; k++) step(1'b1, W'(k * 3 + 2), 1'b1);
    check(both > 0, "R6 simultaneous", both, 1);
    drain();
    check(pushes == pops, "R2 balance", pops, pushes);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule